// File: doc/BRIEF.md
# Microcode Datapath ALU with Sign and Zero Flags

This block is the arithmetic and logic unit of a small microprogrammed datapath. Two 16-bit operands arrive on the A and B buses and a 2-bit function code picks one of four operations. The result leaves combinationally on the same cycle, together with a sign flag and an all-zero flag taken from that result, so the microsequencer can branch on them in the current microinstruction.

A second copy of the two flags is held in a small register for use by the following microinstruction. It loads only on clock edges where the flag-enable input is high. The asynchronous active-low reset clears it at once. Release of that reset is brought into the clock domain through a two-stage synchronizer, so the register begins to load on the third rising edge after reset goes high.

Top module: `mu_alu`

## Requirements
- R1: With fn_sel = 2'b00 the result is bus_a + bus_b truncated to 16 bits, so a sum of 2^16 or more wraps around and no carry appears anywhere.
- R2: With fn_sel = 2'b01 the result is the bitwise AND of bus_a and bus_b.
- R3: With fn_sel = 2'b10 the result equals bus_a, and bus_b has no effect on the result or the flags.
- R4: With fn_sel = 2'b11 the result is the bitwise complement of bus_a, and bus_b has no effect.
- R5: neg equals bit 15 of the result for every function code.
- R6: zero is high exactly when all 16 result bits are zero, for every function code.
- R7: On a rising clock edge with flag_en high and reset fully released, neg_q and zero_q take the values that neg and zero had just before that edge.
- R8: On a rising clock edge with flag_en low, neg_q and zero_q keep their values.
- R9: While rst_n is low, neg_q and zero_q are 0, and they go to 0 as soon as rst_n falls, without waiting for a clock edge. After rst_n rises, the first two rising edges load nothing, and loading begins on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| bus_a | input | 16 | Operand from the A bus |
| bus_b | input | 16 | Operand from the B bus |
| fn_sel | input | 2 | Function code: 00 add, 01 AND, 10 pass A, 11 invert A |
| flag_en | input | 1 | When high, the flag register loads on the next rising edge |
| result | output | 16 | Combinational result |
| neg | output | 1 | Combinational sign flag (result bit 15) |
| zero | output | 1 | Combinational flag, high when the result is all zeros |
| neg_q | output | 1 | Registered sign flag |
| zero_q | output | 1 | Registered zero flag |

## Verification
Addition is tried with small operands, with sums that wrap past 2^16 to exactly zero, and with sums that cross into bit 15. These cases separate true modular wrap from a saturating or carry-leaking adder, and they show that both flags follow the result. AND is driven with overlapping and with disjoint masks, which gives results that are zero and results that are not. Pass and invert are each applied twice with the same A and different B values, so any path from B into these operations shows up. They are also applied with all-ones and all-zeros patterns, which drive the flags to both extremes. The flag register is loaded, then held against changed flags with enable low, and then reset in mid-run both asynchronously and through the delayed synchronous release.

// File: rtl/mu_alu_pkg.sv
package mu_alu_pkg;

  localparam int unsigned DW = 16;
  localparam int unsigned FW = 2;

  typedef enum logic [FW-1:0] {
    FN_ADD  = 2'b00,
    FN_AND  = 2'b01,
    FN_PASS = 2'b10,
    FN_INV  = 2'b11
  } alu_fn_e;

  typedef struct packed {
    logic neg;
    logic zero;
  } alu_flags_t;

endpackage

// File: rtl/mu_alu_rst_sync.sv
module mu_alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mu_alu_core.sv
module mu_alu_core
  import mu_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  alu_fn_e       fn,
  output logic [W-1:0]  res
);

  logic [W-1:0] sum_w;
  logic [W-1:0] and_w;
  logic [W-1:0] inv_w;

  // Adder: truncating to W bits makes it modular with no carry out.
  assign sum_w = op_a + op_b;

  // Per-bit logic slices.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_w[i] = op_a[i] & op_b[i];
    assign inv_w[i] = ~op_a[i];
  end

  always_comb begin
    unique case (fn)
      FN_ADD:  res = sum_w;
      FN_AND:  res = and_w;
      FN_PASS: res = op_a;
      FN_INV:  res = inv_w;
      default: res = op_a;
    endcase
  end

endmodule

// File: rtl/mu_alu_flag_gen.sv
module mu_alu_flag_gen
  import mu_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] res,
  output alu_flags_t   flags
);

  assign flags.neg  = res[W-1];
  assign flags.zero = ~|res;

endmodule

// File: rtl/mu_alu_flag_reg.sv
module mu_alu_flag_reg
  import mu_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  alu_flags_t d,
  output alu_flags_t q
);

  alu_flags_t q_r;
  alu_flags_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  // R7: an enabled edge loads the incoming flags
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d)));

  // R8: a disabled edge leaves the stored flags alone
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/mu_alu.sv
module mu_alu
  import mu_alu_pkg::*;
#(
  parameter int unsigned W          = DW,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_a,
  input  logic [W-1:0] bus_b,
  input  logic [FW-1:0] fn_sel,
  input  logic         flag_en,
  output logic [W-1:0] result,
  output logic         neg,
  output logic         zero,
  output logic         neg_q,
  output logic         zero_q
);

  logic       rst_sync_n;
  alu_fn_e    fn;
  alu_flags_t flags_now;
  alu_flags_t flags_held;

  assign fn = alu_fn_e'(fn_sel);

  mu_alu_rst_sync #(.STAGES(SYNC_DEPTH)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mu_alu_core #(.W(W)) u_core (
    .op_a (bus_a),
    .op_b (bus_b),
    .fn   (fn),
    .res  (result)
  );

  mu_alu_flag_gen #(.W(W)) u_fgen (
    .res   (result),
    .flags (flags_now)
  );

  mu_alu_flag_reg u_freg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (flag_en),
    .d     (flags_now),
    .q     (flags_held)
  );

  assign neg    = flags_now.neg;
  assign zero   = flags_now.zero;
  assign neg_q  = flags_held.neg;
  assign zero_q = flags_held.zero;

  // R2: an AND result never sets a bit that is clear in A
  a_r2_and_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == 2'b01) |-> ((result & ~bus_a) == '0));

  // R3: a nonzero A passed through cannot report zero
  a_r3_pass_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == 2'b10 && bus_a != '0) |-> !zero);

  // R4: the inverted result shares no set bit with A
  a_r4_inv_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == 2'b11) |-> ((result & bus_a) == '0));

  // R5: the sign flag tracks the top result bit
  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    neg == result[W-1]);

  // R6: the zero flag and a nonzero result never coincide
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> (result == '0));

  // R9: the held flags stay cleared while the reset is still being released
  a_r9_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |=> (!neg_q && !zero_q));

endmodule

// File: tb/sim_mu_alu.sv
`timescale 1ns/1ps
module sim_mu_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_a, bus_b;
  logic [1:0]  fn_sel;
  logic        flag_en;
  logic [15:0] result;
  logic        neg, zero, neg_q, zero_q;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mu_alu u0 (
    .clk(clk), .rst_n(rst_n), .bus_a(bus_a), .bus_b(bus_b),
    .fn_sel(fn_sel), .flag_en(flag_en), .result(result),
    .neg(neg), .zero(zero), .neg_q(neg_q), .zero_q(zero_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one combinational vector and compare result and both flags.
  task automatic apply(input string tag, input logic [1:0] f,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] exp);
    @(negedge clk);
    fn_sel = f; bus_a = a; bus_b = b;
    #1;
    chk(tag, {16'h0, result}, {16'h0, exp});
    chk({tag, " R5 neg"}, {31'h0, neg}, {31'h0, exp[15]});
    chk({tag, " R6 zero"}, {31'h0, zero}, {31'h0, (exp == 16'h0)});
  endtask

  task automatic t_reset;
    // R9: held flags cleared while reset is low
    chk("R9 reset neg_q", {31'h0, neg_q}, 32'h0);
    chk("R9 reset zero_q", {31'h0, zero_q}, 32'h0);
    // Drive zero result with enable on, then release reset.
    @(negedge clk);
    fn_sel = 2'b00; bus_a = 16'h0; bus_b = 16'h0; flag_en = 1'b1;
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 no load before sync release", {31'h0, zero_q}, 32'h0);
    @(negedge clk);
    chk("R9 load on third edge", {31'h0, zero_q}, 32'h1);
    flag_en = 1'b0;
  endtask

  task automatic t_add;
    apply("R1 add small", 2'b00, 16'h0012, 16'h0034, 16'h0046);
    apply("R1 add wrap to zero", 2'b00, 16'hFFFF, 16'h0001, 16'h0000);
    apply("R1 add wrap partial", 2'b00, 16'hF000, 16'h2345, 16'h1345);
    apply("R1 add into sign", 2'b00, 16'h7FFF, 16'h0001, 16'h8000);
  endtask

  task automatic t_and;
    apply("R2 and overlap", 2'b01, 16'hF0F0, 16'hFF00, 16'hF000);
    apply("R2 and disjoint", 2'b01, 16'hAAAA, 16'h5555, 16'h0000);
    apply("R2 and sign", 2'b01, 16'h8001, 16'hFFFF, 16'h8001);
  endtask

  task automatic t_pass;
    apply("R3 pass b=0", 2'b10, 16'h1234, 16'h0000, 16'h1234);
    apply("R3 pass b=ffff", 2'b10, 16'h1234, 16'hFFFF, 16'h1234);
    apply("R3 pass zero a", 2'b10, 16'h0000, 16'hBEEF, 16'h0000);
    apply("R3 pass neg a", 2'b10, 16'h9000, 16'h0001, 16'h9000);
  endtask

  task automatic t_inv;
    apply("R4 inv ones", 2'b11, 16'hFFFF, 16'h0000, 16'h0000);
    apply("R4 inv ones b changed", 2'b11, 16'hFFFF, 16'h1357, 16'h0000);
    apply("R4 inv zeros", 2'b11, 16'h0000, 16'h0000, 16'hFFFF);
    apply("R4 inv mixed", 2'b11, 16'h0F0F, 16'hFFFF, 16'hF0F0);
  endtask

  task automatic t_capture;
    // R7: load neg=1 zero=0
    @(negedge clk);
    fn_sel = 2'b10; bus_a = 16'h8000; flag_en = 1'b1;
    @(negedge clk);
    chk("R7 load neg_q", {31'h0, neg_q}, 32'h1);
    chk("R7 load zero_q", {31'h0, zero_q}, 32'h0);
    // R7: load neg=0 zero=1
    fn_sel = 2'b01; bus_a = 16'h00FF; bus_b = 16'hFF00;
    @(negedge clk);
    chk("R7 reload neg_q", {31'h0, neg_q}, 32'h0);
    chk("R7 reload zero_q", {31'h0, zero_q}, 32'h1);
  endtask

  task automatic t_hold;
    // R8: enable low, flags change, held copy stays
    flag_en = 1'b0;
    fn_sel = 2'b11; bus_a = 16'h0001;
    @(negedge clk); @(negedge clk);
    chk("R8 hold neg_q", {31'h0, neg_q}, 32'h0);
    chk("R8 hold zero_q", {31'h0, zero_q}, 32'h1);
  endtask

  task automatic t_async;
    // Load neg=1, then reset between edges.
    flag_en = 1'b1;
    @(negedge clk);
    chk("R7 pre-reset neg_q", {31'h0, neg_q}, 32'h1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R9 async clear neg_q", {31'h0, neg_q}, 32'h0);
    chk("R9 async clear zero_q", {31'h0, zero_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 still clear after two edges", {31'h0, neg_q}, 32'h0);
    @(negedge clk);
    chk("R9 resumes loading", {31'h0, neg_q}, 32'h1);
    flag_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; flag_en = 1'b0; fn_sel = 2'b00;
    bus_a = 16'h0; bus_b = 16'h0;
    #12;
    t_reset;
    t_add;
    t_and;
    t_pass;
    t_inv;
    t_capture;
    t_hold;
    t_async;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule